// File: doc/BRIEF.md
# Eight-Point Hartley Transform Engine

This block computes the discrete Hartley transform of one frame of eight signed 10-bit real samples. It returns eight signed 13-bit real coefficients, where coefficient k is the sum over n of x[n]·cas(2πnk/8) and cas(θ) = cos θ + sin θ. The engine is built for a front end that turns image blocks into a less correlated domain before thresholding and entropy coding.

The datapath starts with a radix-2 butterfly on input pairs n and n+4. The even coefficients come from a multiplier-free four-point transform of the pair sums. The odd coefficients need the factor √2 on exactly four raw inputs: x1, x5, x3 and x7. That factor is applied by one shared constant-multiplier unit. The unit holds two multiplier lanes, and each lane is steered by a slot counter over two operands. The products land in holding registers, and one final add/subtract stage forms all eight coefficients.

A frame is offered on a parallel bus and accepted with a start/ready handshake. The results appear on a parallel bus together with a one-cycle valid strobe.

Top module: `dht8_core`

## Requirements
- R1: Sample n is taken from `inData[10n+9:10n]` and coefficient k is driven on `outData[13k+12:13k]`, both in two's complement. Every 10-bit input frame, including all samples at -512 or all at +511, produces results with no wrap-around.
- R2: Even coefficients are exact integer sums. With a[n] = x[n]+x[n+4] for n = 0..3: X0=a0+a1+a2+a3, X2=a0+a1-a2-a3, X4=a0-a1+a2-a3, X6=a0-a1-a2+a3.
- R3: Odd coefficients are formed as follows. With b[n] = x[n]-x[n+4] and p(v) = floor((362·v + 128)/256), which is √2 in 8 fractional bits rounded half up: X1=b0+b2+p(x1)-p(x5), X5=b0+b2-p(x1)+p(x5), X3=b0-b2+p(x3)-p(x7), X7=b0-b2-p(x3)+p(x7).
- R4: After reset, `ready` is 1, `outValid` is 0 and `outData` is 0.
- R5: A frame is accepted on a rising edge where `start` and `ready` are both 1. `ready` is 0 for the next three cycles and is 1 again in the cycle where `outValid` is 1.
- R6: `outValid` is 1 for exactly one cycle, four rising edges after the edge that accepted the frame.
- R7: `start` is ignored while `ready` is 0. The result reported is that of the frame already accepted, and no extra `outValid` pulse follows.
- R8: `outData` holds its value from one `outValid` pulse until the next.
- R9: A new frame may be accepted in the same cycle in which `outValid` is 1.
- R10: Transforming the coefficients again in real arithmetic and dividing by 8 returns every input sample within ±1.
- R11: Each odd coefficient lies within 2 of the exact real transform value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to accept the frame on inData |
| inData | input | 80 | Eight signed 10-bit samples, sample n at bits 10n+9:10n |
| ready | output | 1 | High when a frame can be accepted |
| outValid | output | 1 | One-cycle strobe marking a fresh result |
| outData | output | 104 | Eight signed 13-bit coefficients, coefficient k at bits 13k+12:13k |

## Verification
Several properties are checked on every cycle:
- the valid pulse lasts one cycle and arrives at a fixed distance from an accepted start;
- the captured frame stays still while the engine is busy;
- the results hold between pulses;
- every stored product stays inside the bound set by the 10-bit range and the constant.

The numeric content can only be shown by the bench scenarios. These cover the rounding of each product, the even and odd combinations, full-scale frames, the round trip back to the inputs, and the handling of starts that arrive while busy or on the strobe cycle.

// File: rtl/dht8_pkg.sv
package dht8_pkg;
  // Transform length is fixed by the decomposition used in the datapath
  localparam int DHT_N     = 8;
  localparam int HALF_N    = DHT_N / 2;
  // Shared constant multiplier: lanes times slots covers the odd inputs
  localparam int MUL_LANES = 2;
  localparam int MUL_SLOTS = 2;
  localparam int MUL_OPS   = MUL_LANES * MUL_SLOTS;
  localparam int SLOT_W    = (MUL_SLOTS > 1) ? $clog2(MUL_SLOTS) : 1;

  // Strobes from control to datapath
  typedef struct packed {
    logic              capture;
    logic              mulEn;
    logic [SLOT_W-1:0] slot;
    logic              finish;
    logic              busy;
  } dhtCtrl_t;
endpackage

// File: rtl/dht8_ctrl.sv
module dht8_ctrl
  import dht8_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  output logic     ready,
  output logic     outValid,
  output dhtCtrl_t ctl
);
  typedef enum logic [1:0] {S_IDLE, S_MUL, S_SUM} state_t;

  state_t            state;
  logic [SLOT_W-1:0] slotCnt;
  logic              validQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= S_IDLE;
      slotCnt <= '0;
      validQ  <= 1'b0;
    end else begin
      validQ <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            state   <= S_MUL;
            slotCnt <= '0;
          end
        end
        S_MUL: begin
          if (slotCnt == SLOT_W'(MUL_SLOTS - 1)) begin
            state   <= S_SUM;
            slotCnt <= '0;
          end else begin
            slotCnt <= slotCnt + 1'b1;
          end
        end
        S_SUM: begin
          state  <= S_IDLE;
          validQ <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.capture = (state == S_IDLE) && start;
    ctl.mulEn   = (state == S_MUL);
    ctl.slot    = slotCnt;
    ctl.finish  = (state == S_SUM);
    ctl.busy    = (state != S_IDLE);
  end

  assign ready    = (state == S_IDLE);
  assign outValid = validQ;

  // R6
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && ready) |-> ##4 outValid);

  // R5
  ready_on_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> ready);
endmodule

// File: rtl/dht8_cmul.sv
module dht8_cmul #(
  parameter int DATA_W  = 10,
  parameter int CONST_W = 9,
  parameter int FRAC_W  = 8,
  parameter int CONST_Q = 362,
  parameter int LANES   = 2,
  parameter int SLOTS   = 2,
  parameter int SEL_W   = 1
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             mulEn,
  input  logic [SEL_W-1:0]                 slot,
  input  logic [LANES*SLOTS*DATA_W-1:0]    operands,
  output logic [LANES*SLOTS*(DATA_W+1)-1:0] products
);
  localparam int RES_W = DATA_W + 1;
  localparam int PRD_W = DATA_W + CONST_W + 1;
  localparam int PMAX  = ((1 << (DATA_W - 1)) * CONST_Q + (1 << (FRAC_W - 1))) >> FRAC_W;

  logic signed [RES_W-1:0] hold [LANES*SLOTS];

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic signed [DATA_W-1:0] opSel;
    logic signed [PRD_W-1:0]  prodFull;
    logic signed [PRD_W-1:0]  prodRnd;
    logic signed [RES_W-1:0]  rounded;

    // Input multiplexer: the slot picks this lane's operand
    assign opSel    = $signed(operands[(lane*SLOTS + int'(slot))*DATA_W +: DATA_W]);
    assign prodFull = PRD_W'(opSel) * $signed(PRD_W'(CONST_Q));
    assign prodRnd  = prodFull + PRD_W'(1 << (FRAC_W - 1));
    assign rounded  = RES_W'(prodRnd >>> FRAC_W);

    // Output demultiplexer into per-operand holding registers
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      localparam int IDX = lane*SLOTS + s;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          hold[IDX] <= '0;
        else if (mulEn && (slot == SEL_W'(s)))
          hold[IDX] <= rounded;
      end
      assign products[IDX*RES_W +: RES_W] = hold[IDX];

      // R1
      product_range_chk: assert property (@(posedge clk) disable iff (!rstN)
        (hold[IDX] >= -PMAX) && (hold[IDX] <= PMAX));
    end
  end
endmodule

// File: rtl/dht8_datapath.sv
module dht8_datapath
  import dht8_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int OUT_W   = 13,
  parameter int CONST_Q = 362,
  parameter int FRAC_W  = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dhtCtrl_t                ctl,
  input  logic [DHT_N*DATA_W-1:0] inData,
  output logic [DHT_N*OUT_W-1:0]  outData
);
  localparam int RES_W   = DATA_W + 1;
  localparam int CONST_W = $clog2(CONST_Q + 1);

  logic [DHT_N-1:0][DATA_W-1:0] xReg;
  logic [DHT_N-1:0][OUT_W-1:0]  yReg;
  logic [MUL_OPS*DATA_W-1:0]    operands;
  logic [MUL_OPS*RES_W-1:0]     prodFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      xReg <= '0;
    else if (ctl.capture)
      xReg <= inData;
  end

  // Lane 0 serves x1 then x5, lane 1 serves x3 then x7
  assign operands = {xReg[7], xReg[3], xReg[5], xReg[1]};

  dht8_cmul #(
    .DATA_W (DATA_W),
    .CONST_W(CONST_W),
    .FRAC_W (FRAC_W),
    .CONST_Q(CONST_Q),
    .LANES  (MUL_LANES),
    .SLOTS  (MUL_SLOTS),
    .SEL_W  (SLOT_W)
  ) u_cmul (
    .clk     (clk),
    .rstN    (rstN),
    .mulEn   (ctl.mulEn),
    .slot    (ctl.slot),
    .operands(operands),
    .products(prodFlat)
  );

  // First butterfly on pairs n and n+4
  logic signed [OUT_W-1:0] aSum [HALF_N];
  logic signed [OUT_W-1:0] bDif [HALF_N];
  for (genvar n = 0; n < HALF_N; n++) begin : g_bfly
    assign aSum[n] = OUT_W'($signed(xReg[n])) + OUT_W'($signed(xReg[n+HALF_N]));
    assign bDif[n] = OUT_W'($signed(xReg[n])) - OUT_W'($signed(xReg[n+HALF_N]));
  end

  logic signed [OUT_W-1:0] pX1, pX5, pX3, pX7;
  assign pX1 = OUT_W'($signed(prodFlat[0*RES_W +: RES_W]));
  assign pX5 = OUT_W'($signed(prodFlat[1*RES_W +: RES_W]));
  assign pX3 = OUT_W'($signed(prodFlat[2*RES_W +: RES_W]));
  assign pX7 = OUT_W'($signed(prodFlat[3*RES_W +: RES_W]));

  // Shared partial sums for the even half
  logic signed [OUT_W-1:0] s01, d01, s23, d23;
  assign s01 = aSum[0] + aSum[1];
  assign d01 = aSum[0] - aSum[1];
  assign s23 = aSum[2] + aSum[3];
  assign d23 = aSum[2] - aSum[3];

  // Shared partial sums for the odd half
  logic signed [OUT_W-1:0] eSum, fDif, g1, g3;
  assign eSum = bDif[0] + bDif[2];
  assign fDif = bDif[0] - bDif[2];
  assign g1   = pX1 - pX5;
  assign g3   = pX3 - pX7;

  logic [DHT_N-1:0][OUT_W-1:0] yNext;
  always_comb begin
    yNext[0] = s01 + s23;
    yNext[2] = s01 - s23;
    yNext[4] = d01 + d23;
    yNext[6] = d01 - d23;
    yNext[1] = eSum + g1;
    yNext[5] = eSum - g1;
    yNext[3] = fDif + g3;
    yNext[7] = fDif - g3;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      yReg <= '0;
    else if (ctl.finish)
      yReg <= yNext;
  end

  assign outData = yReg;

  // R7
  frame_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.busy |=> $stable(xReg));

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.finish |=> $stable(yReg));
endmodule

// File: rtl/dht8_core.sv
module dht8_core
  import dht8_pkg::*;
#(
  parameter int DATA_W  = 10,
  parameter int CONST_Q = 362,
  parameter int FRAC_W  = 8,
  localparam int OUT_W  = DATA_W + 3
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [DHT_N*DATA_W-1:0] inData,
  output logic                    ready,
  output logic                    outValid,
  output logic [DHT_N*OUT_W-1:0]  outData
);
  dhtCtrl_t ctl;

  dht8_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .ready   (ready),
    .outValid(outValid),
    .ctl     (ctl)
  );

  dht8_datapath #(
    .DATA_W (DATA_W),
    .OUT_W  (OUT_W),
    .CONST_Q(CONST_Q),
    .FRAC_W (FRAC_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .ctl    (ctl),
    .inData (inData),
    .outData(outData)
  );
endmodule

// File: tb/dht8_core_bench.sv
`timescale 1ns/1ps
module dht8_core_bench;
  localparam int DW = 10;
  localparam int OW = 13;
  localparam real PI = 3.14159265358979;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [8*DW-1:0] inData = '0;
  logic ready, outValid;
  logic [8*OW-1:0] outData;

  int errors = 0;
  int checks = 0;
  int got [8];
  logic [31:0] seed = 32'h1234_5678;

  always #2 clk = ~clk;

  dht8_core u_dht8_core (
    .clk(clk), .rstN(rstN), .start(start), .inData(inData),
    .ready(ready), .outValid(outValid), .outData(outData)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pr(input int v);
    return (v * 362 + 128) >>> 8;
  endfunction

  function automatic int refCoef(input int x[8], input int k);
    int a[4], b[4];
    for (int n = 0; n < 4; n++) begin
      a[n] = x[n] + x[n+4];
      b[n] = x[n] - x[n+4];
    end
    case (k)
      0: return a[0] + a[1] + a[2] + a[3];
      2: return a[0] + a[1] - a[2] - a[3];
      4: return a[0] - a[1] + a[2] - a[3];
      6: return a[0] - a[1] - a[2] + a[3];
      1: return b[0] + b[2] + pr(x[1]) - pr(x[5]);
      5: return b[0] + b[2] - pr(x[1]) + pr(x[5]);
      3: return b[0] - b[2] + pr(x[3]) - pr(x[7]);
      default: return b[0] - b[2] - pr(x[3]) + pr(x[7]);
    endcase
  endfunction

  function automatic real casv(input int m);
    real t;
    t = 2.0 * PI * real'(m) / 8.0;
    return $cos(t) + $sin(t);
  endfunction

  task automatic loadFrame(input int x[8]);
    for (int n = 0; n < 8; n++) inData[n*DW +: DW] = DW'(x[n]);
  endtask

  task automatic readOut();
    for (int k = 0; k < 8; k++) got[k] = int'($signed(outData[k*OW +: OW]));
  endtask

  task automatic compareRef(input int x[8], input string req);
    readOut();
    for (int k = 0; k < 8; k++)
      chk(got[k] == refCoef(x, k), req, $sformatf("coef %0d", k), got[k], refCoef(x, k));
  endtask

  // One frame with handshake and timing checks (R5, R6)
  task automatic runFrame(input int x[8], input string req);
    @(negedge clk);
    loadFrame(x);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R5", "ready low after accept", int'(ready), 0);
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 1'b0, "R6", "no early valid", int'(outValid), 0);
    @(negedge clk);
    chk(outValid == 1'b1, "R6", "valid at fourth edge", int'(outValid), 1);
    chk(ready == 1'b1, "R5", "ready back with valid", int'(ready), 1);
    compareRef(x, req);
    @(negedge clk);
    chk(outValid == 1'b0, "R6", "valid one cycle", int'(outValid), 0);
  endtask

  task automatic testReset();
    chk(ready == 1'b1, "R4", "ready after reset", int'(ready), 1);
    chk(outValid == 1'b0, "R4", "valid after reset", int'(outValid), 0);
    chk(outData == '0, "R4", "data after reset", int'(outData[31:0]), 0);
  endtask

  task automatic testImpulses();
    int x[8];
    x = '{100, 0, 0, 0, 0, 0, 0, 0};
    runFrame(x, "R2");
    for (int k = 0; k < 8; k++) chk(got[k] == 100, "R2", "dc impulse", got[k], 100);
    x = '{0, 5, 0, 0, 0, 0, 0, 0};
    runFrame(x, "R3");
    chk(got[1] == 7, "R3", "rounded sqrt2 term", got[1], 7);
    x = '{0, 0, 0, -1, 0, 0, 0, 0};
    runFrame(x, "R3");
    x = '{0, 0, 0, 0, 0, 3, 0, -7};
    runFrame(x, "R3");
  endtask

  task automatic testFullScale();
    int x[8];
    x = '{-512, -512, -512, -512, -512, -512, -512, -512};
    runFrame(x, "R1");
    chk(got[0] == -4096, "R1", "all negative dc", got[0], -4096);
    x = '{511, 511, 511, 511, 511, 511, 511, 511};
    runFrame(x, "R1");
    chk(got[0] == 4088, "R1", "all positive dc", got[0], 4088);
    x = '{511, 511, 511, -512, -512, -512, 511, 511};
    runFrame(x, "R1");
    x = '{511, 511, -512, 511, -512, -512, 511, -512};
    runFrame(x, "R1");
  endtask

  task automatic testRandom(input int frames);
    int x[8];
    for (int f = 0; f < frames; f++) begin
      for (int n = 0; n < 8; n++) begin
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        x[n] = int'($signed(seed[DW-1:0]));
      end
      runFrame(x, "R3");
      for (int k = 1; k < 8; k += 2) begin
        real exact = 0.0;
        for (int n = 0; n < 8; n++) exact += real'(x[n]) * casv(n * k);
        chk((real'(got[k]) - exact <= 2.0) && (exact - real'(got[k]) <= 2.0),
            "R11", "odd coef near exact", got[k], int'(exact));
      end
      for (int n = 0; n < 8; n++) begin
        real back = 0.0;
        for (int k = 0; k < 8; k++) back += real'(got[k]) * casv(n * k);
        back = back / 8.0;
        chk((back - real'(x[n]) <= 1.0) && (real'(x[n]) - back <= 1.0),
            "R10", "round trip", int'(back), x[n]);
      end
    end
  endtask

  task automatic testBusyStart();
    int xa[8], xb[8], keep[8];
    xa = '{10, -20, 30, -40, 50, -60, 70, -80};
    xb = '{-300, 300, -300, 300, -300, 300, -300, 300};
    @(negedge clk);
    loadFrame(xa);
    start = 1'b1;
    @(negedge clk);
    loadFrame(xb);
    @(negedge clk);
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk(outValid == 1'b1, "R7", "valid while start held", int'(outValid), 1);
    compareRef(xa, "R7");
    keep = got;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      chk(outValid == 1'b0, "R7", "no extra pulse", int'(outValid), 0);
      readOut();
      chk(got[3] == keep[3] && got[0] == keep[0], "R8", "result held", got[3], keep[3]);
    end
  endtask

  task automatic testBackToBack();
    int xa[8], xb[8];
    xa = '{1, 2, 3, 4, 5, 6, 7, 8};
    xb = '{-9, 17, -25, 33, 41, -49, 57, -65};
    @(negedge clk);
    loadFrame(xa);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 1'b1 && ready == 1'b1, "R9", "first result", int'(outValid), 1);
    compareRef(xa, "R9");
    loadFrame(xb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(ready == 1'b0, "R9", "second frame accepted", int'(ready), 0);
    @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    chk(outValid == 1'b1, "R9", "second result valid", int'(outValid), 1);
    compareRef(xb, "R9");
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testImpulses();
    testFullScale();
    testBusyStart();
    testBackToBack();
    testRandom(60);
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule